// File: doc/BRIEF.md
# Dual-Channel Window Threshold Monitor

This block watches a stream of 10-bit conversion results. Each result arrives with a channel index and a valid strobe. Two channel slots, A and B, are checked against their own programmable window. Slot A takes the channel named by a select field, and slot B takes the channel after it, wrapping at the top of the index range. A result in either slot that leaves its window sets a sticky flag. The flag records which slot was hit and which limit was crossed. The same result also sets a request flag, which drives a maskable interrupt line.

The window is asymmetric. A result equal to the upper limit or above it is out of range. A result equal to the lower limit is still in range. Only a result strictly below the lower limit is out of range on that side. Software acknowledges an event by pulsing a clear input. That pulse drops the request flag, and the four result flags are cleared in hardware together with it. The flag field is eight bits wide. Its low four bits always read as zero.

Top module: `dual_window_monitor`

## Requirements
- R1: Slot A monitors the channel equal to `sel_chan`. Slot B monitors channel `sel_chan+1` modulo 16, so a select of 15 maps slot B to channel 0. Results on any other channel change nothing.
- R2: A valid slot-A result greater than or equal to `a_upper` sets `flags_o[7]` at the next clock edge.
- R3: A valid slot-A result strictly below `a_lower` sets `flags_o[6]`. A result equal to `a_lower` sets no flag.
- R4: Slot B follows the same rules as slot A, using `b_upper` and `b_lower`. Its upper condition sets `flags_o[5]` and its lower condition sets `flags_o[4]`.
- R5: A result with lower ≤ value < upper sets no flag and raises no interrupt.
- R6: `flags_o[3:0]` is always zero.
- R7: Flags are sticky. They accumulate across results. In-range results, and cycles with `res_valid` low, leave them unchanged.
- R8: A `req_clear` pulse with no violation in the same cycle clears the request and all four flags at the next edge.
- R9: A `req_clear` in the same cycle as a violation clears the older flags. Only the new violation's bits remain set, and the request stays set.
- R10: `irq_o` is registered. At each edge it loads the next request state ANDed with `irq_mask_en`.
- R11: Synchronous active-high reset clears all flags, the request and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Result strobe |
| res_chan | input | 4 | Channel index of the result |
| res_data | input | 10 | Conversion result |
| sel_chan | input | 4 | Channel assigned to slot A (slot B is the next channel) |
| a_upper | input | 10 | Slot A upper limit |
| a_lower | input | 10 | Slot A lower limit |
| b_upper | input | 10 | Slot B upper limit |
| b_lower | input | 10 | Slot B lower limit |
| irq_mask_en | input | 1 | Interrupt enable |
| req_clear | input | 1 | Software clear of the request flag |
| flags_o | output | 8 | Result flags: bit 7 A upper, bit 6 A lower, bit 5 B upper, bit 4 B lower, bits 3:0 zero |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can act in the same clock cycle: the software clear of the request and a new out-of-range result. The bench drives `req_clear` together with a valid slot-B low result while slot-A flags are already set. It then checks two things at the next edge. The older bits must be gone, and only the new bit may remain. The request and interrupt must still be asserted. A clear without a result is also checked on its own, so the two outcomes can be told apart.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  // Flag field layout
  localparam int unsigned FLAG_W     = 8;
  localparam int unsigned NUM_SLOT   = 2;
  localparam int unsigned HIT_W      = 2 * NUM_SLOT;
  localparam int unsigned UNUSED_W   = FLAG_W - HIT_W;

  // Per-slot comparison outcome
  typedef struct packed {
    logic over;   // value >= upper limit
    logic under;  // value <  lower limit
  } slot_hit_t;

endpackage

// File: rtl/wwd_slot_route.sv
module wwd_slot_route #(
  parameter int unsigned CH_W = 4
) (
  input  logic [CH_W-1:0]            sel_chan,
  input  logic [CH_W-1:0]            res_chan,
  input  logic                       res_valid,
  output logic [wwd_pkg::NUM_SLOT-1:0] slot_en
);
  // Slot k monitors channel sel_chan + k, wrapping in CH_W bits
  for (genvar k = 0; k < int'(wwd_pkg::NUM_SLOT); k++) begin : g_slot
    logic [CH_W-1:0] target;
    assign target     = sel_chan + CH_W'(k);
    assign slot_en[k] = res_valid && (res_chan == target);
  end
endmodule

// File: rtl/wwd_window_cmp.sv
module wwd_window_cmp #(
  parameter int unsigned DATA_W = 10
) (
  input  logic                 en,
  input  logic [DATA_W-1:0]    value,
  input  logic [DATA_W-1:0]    upper,
  input  logic [DATA_W-1:0]    lower,
  output wwd_pkg::slot_hit_t   hit
);
  // Asymmetric window: upper inclusive out, lower inclusive in
  always_comb begin
    hit.over  = en && (value >= upper);
    hit.under = en && (value <  lower);
  end
endmodule

// File: rtl/wwd_flag_reg.sv
module wwd_flag_reg (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [wwd_pkg::HIT_W-1:0]      hit_vec,
  input  logic                           clr,
  input  logic                           mask_en,
  output logic [wwd_pkg::FLAG_W-1:0]     flags_o,
  output logic                           irq_o
);
  import wwd_pkg::*;

  logic [HIT_W-1:0] flag_q, flag_nxt;
  logic             req_q, req_nxt;
  logic             irq_q;

  // Clear applies to held state; same-cycle hits still land
  always_comb begin
    flag_nxt = (clr ? '0 : flag_q) | hit_vec;
    req_nxt  = (clr ? 1'b0 : req_q) | (|hit_vec);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      req_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      req_q  <= req_nxt;
      irq_q  <= req_nxt & mask_en;
    end
  end

  assign flags_o = {flag_q, {UNUSED_W{1'b0}}};
  assign irq_o   = irq_q;
endmodule

// File: rtl/dual_window_monitor.sv
module dual_window_monitor #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data,
  input  logic [CH_W-1:0]   sel_chan,
  input  logic [DATA_W-1:0] a_upper,
  input  logic [DATA_W-1:0] a_lower,
  input  logic [DATA_W-1:0] b_upper,
  input  logic [DATA_W-1:0] b_lower,
  input  logic              irq_mask_en,
  input  logic              req_clear,
  output logic [7:0]        flags_o,
  output logic              irq_o
);
  import wwd_pkg::*;

  logic [NUM_SLOT-1:0] slot_en;
  logic [DATA_W-1:0]   up_lim [NUM_SLOT];
  logic [DATA_W-1:0]   lo_lim [NUM_SLOT];
  logic [HIT_W-1:0]    hit_vec;

  assign up_lim[0] = a_upper;
  assign lo_lim[0] = a_lower;
  assign up_lim[1] = b_upper;
  assign lo_lim[1] = b_lower;

  wwd_slot_route #(.CH_W(CH_W)) u_route (
    .sel_chan  (sel_chan),
    .res_chan  (res_chan),
    .res_valid (res_valid),
    .slot_en   (slot_en)
  );

  // Slot 0 occupies the top pair of the hit vector
  for (genvar k = 0; k < int'(NUM_SLOT); k++) begin : g_cmp
    slot_hit_t hit;
    wwd_window_cmp #(.DATA_W(DATA_W)) u_cmp (
      .en    (slot_en[k]),
      .value (res_data),
      .upper (up_lim[k]),
      .lower (lo_lim[k]),
      .hit   (hit)
    );
    assign hit_vec[HIT_W-1-2*k] = hit.over;
    assign hit_vec[HIT_W-2-2*k] = hit.under;
  end

  wwd_flag_reg u_flags (
    .clk     (clk),
    .rst     (rst),
    .hit_vec (hit_vec),
    .clr     (req_clear),
    .mask_en (irq_mask_en),
    .flags_o (flags_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned CH_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              res_valid,
  input logic [CH_W-1:0]   res_chan,
  input logic [DATA_W-1:0] res_data,
  input logic [CH_W-1:0]   sel_chan,
  input logic [DATA_W-1:0] a_upper,
  input logic [DATA_W-1:0] b_lower,
  input logic              irq_mask_en,
  input logic              req_clear,
  input logic [7:0]        flags_o,
  input logic              irq_o
);
  logic [CH_W-1:0] b_chan;
  assign b_chan = sel_chan + CH_W'(1);

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (flags_o == 8'h00 && !irq_o));

  assert_a_upper_R2: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_chan == sel_chan && res_data >= a_upper) |=> flags_o[7]);

  assert_b_lower_R4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_chan == b_chan && res_data < b_lower) |=> flags_o[4]);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !req_clear |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (req_clear && !res_valid) |=> (flags_o == 8'h00 && !irq_o));

  assert_mask_R10: assert property (@(posedge clk) disable iff (rst)
    !irq_mask_en |=> !irq_o);

  assert_irq_has_flag_R10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flags_o != 8'h00));
endmodule

bind dual_window_monitor wwd_checker #(.DATA_W(DATA_W), .CH_W(CH_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .res_valid   (res_valid),
  .res_chan    (res_chan),
  .res_data    (res_data),
  .sel_chan    (sel_chan),
  .a_upper     (a_upper),
  .b_lower     (b_lower),
  .irq_mask_en (irq_mask_en),
  .req_clear   (req_clear),
  .flags_o     (flags_o),
  .irq_o       (irq_o)
);

// File: tb/dual_window_monitor_test.sv
`timescale 1ns/1ps
module dual_window_monitor_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       res_valid = 1'b0;
  logic [3:0] res_chan = '0;
  logic [9:0] res_data = '0;
  logic [3:0] sel_chan = 4'd3;
  logic [9:0] a_upper = 10'd600, a_lower = 10'd200;
  logic [9:0] b_upper = 10'd900, b_lower = 10'd100;
  logic       irq_mask_en = 1'b1;
  logic       req_clear = 1'b0;
  logic [7:0] flags_o;
  logic       irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  dual_window_monitor uut (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .sel_chan(sel_chan), .a_upper(a_upper),
    .a_lower(a_lower), .b_upper(b_upper), .b_lower(b_lower),
    .irq_mask_en(irq_mask_en), .req_clear(req_clear),
    .flags_o(flags_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic       clr;
    logic       vld;
    logic [3:0] ch;
    logic [9:0] d;
    logic [7:0] exp;
    logic [7:0] req;
  } vec_t;

  // Slot A = ch3 [200,600), slot B = ch4 [100,900), mask on
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 4'd3, 10'd400,  8'h00, 8'd5},  // R5 in range
    '{1'b0, 1'b1, 4'd3, 10'd200,  8'h00, 8'd3},  // R3 equal lower
    '{1'b0, 1'b1, 4'd3, 10'd199,  8'h40, 8'd3},  // R3 below lower
    '{1'b0, 1'b1, 4'd3, 10'd400,  8'h40, 8'd7},  // R7 sticky
    '{1'b0, 1'b1, 4'd3, 10'd600,  8'hC0, 8'd2},  // R2 equal upper
    '{1'b0, 1'b1, 4'd5, 10'd1023, 8'hC0, 8'd1},  // R1 other channel
    '{1'b0, 1'b1, 4'd4, 10'd899,  8'hC0, 8'd5},  // R5 slot B in range
    '{1'b0, 1'b1, 4'd4, 10'd900,  8'hE0, 8'd4},  // R4 B upper
    '{1'b0, 1'b1, 4'd4, 10'd99,   8'hF0, 8'd4},  // R4 B lower
    '{1'b0, 1'b0, 4'd3, 10'd0,    8'hF0, 8'd7},  // R7 no strobe
    '{1'b1, 1'b0, 4'd3, 10'd0,    8'h00, 8'd8},  // R8 clear
    '{1'b0, 1'b1, 4'd3, 10'd1000, 8'h80, 8'd2},  // R2 again
    '{1'b1, 1'b1, 4'd4, 10'd50,   8'h10, 8'd9},  // R9 clear + hit
    '{1'b1, 1'b0, 4'd0, 10'd0,    8'h00, 8'd8}   // R8 clear
  };

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at negedge, let one edge pass, sample at the next negedge
  task automatic step(input logic clr, input logic vld, input logic [3:0] ch,
                      input logic [9:0] d);
    req_clear = clr; res_valid = vld; res_chan = ch; res_data = d;
    @(posedge clk);
    @(negedge clk);
    req_clear = 1'b0; res_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 flags after reset", int'(flags_o), 8'h00);
    check("R11 irq after reset", int'(irq_o), 0);
    // R6 low nibble zero is checked on every vector below
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].clr, VECS[i].vld, VECS[i].ch, VECS[i].d);
      check($sformatf("R%0d vec%0d flags", VECS[i].req, i), int'(flags_o), int'(VECS[i].exp));
      check($sformatf("R10 vec%0d irq", i), int'(irq_o), int'(VECS[i].exp != 8'h00));
      check($sformatf("R6 vec%0d low nibble", i), int'(flags_o[3:0]), 0);
    end
    // R1 wrap: select 15 maps slot B to channel 0
    sel_chan = 4'd15;
    step(1'b0, 1'b1, 4'd0, 10'd950);
    check("R1 wrap B upper", int'(flags_o), 8'h20);
    step(1'b0, 1'b1, 4'd15, 10'd150);
    check("R1 wrap A lower", int'(flags_o), 8'h60);
    // R10 mask: irq drops after one edge, flags kept
    irq_mask_en = 1'b0;
    step(1'b0, 1'b0, 4'd0, 10'd0);
    check("R10 masked irq", int'(irq_o), 0);
    check("R10 masked flags held", int'(flags_o), 8'h60);
    irq_mask_en = 1'b1;
    step(1'b0, 1'b0, 4'd0, 10'd0);
    check("R10 unmasked irq", int'(irq_o), 1);
    // R11 reset with flags set
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R11 flags after mid reset", int'(flags_o), 8'h00);
    check("R11 irq after mid reset", int'(irq_o), 0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule